// File: doc/BRIEF.md
# Seconds Real-Time Counter with Alarm

This block keeps a 32-bit count of elapsed seconds and compares it with a programmable alarm value. Every register is eight bits wide and is reached one byte per transaction through a small register port: a byte address, a write strobe with write data, and a read strobe whose result appears on the read data bus after the clock edge. The count advances on a one-cycle seconds enable (`sec_tick`), which may come from a prescaler or from a slow timebase synchronised into this clock domain.

Software sets the time by first writing zero to the low byte of the load window. It then writes the upper three bytes into staging registers, which have no effect on the count yet. A final write of the real low byte moves all four bytes into the counter at once. Because software reads the live count one byte at a time, a read can straddle a carry. Software detects this by reading the low byte a second time and repeating the read when the second value is smaller than the first. The alarm flag is a level that stays set until software writes zero to its bit, and it drives the interrupt output directly.

Top module: `sec_rtc`

## Requirements
- R1: After reset the count, the control register, the staging bytes, the alarm value and the pending flag are all zero, `reg_rdata` is zero and `alarm_irq` is low.
- R2: Offset 0x00 is a control register whose eight bits read back as written. Bit 7 enables counting and bit 1 enables the alarm. Offsets 0x06 to 0x09 return the live count, with 0x06 holding bits 7:0 and 0x09 holding bits 31:24.
- R3: While control bit 7 is 0 the count holds its value. While it is 1, each cycle with `sec_tick` high adds one to the count.
- R4: Writes to offsets 0x03, 0x04 and 0x05 stage bytes 1, 2 and 3 and leave the count unchanged. A write to offset 0x02 loads {byte 3, byte 2, byte 1, written data} into the count in that cycle, and it takes precedence over a tick in the same cycle. Offsets 0x02 to 0x05 read as zero.
- R5: Offsets 0x0A to 0x0D hold the alarm value, with 0x0A holding bits 7:0, and they read back as written.
- R6: When the count steps on a tick to a value equal to the alarm value while control bit 1 is 1, the pending flag is set at that same edge. No flag is set while bit 1 is 0, and none is set when a load makes the count equal to the alarm value. `alarm_irq` equals the pending flag.
- R7: Bit 0 of offset 0x01 reads as the pending flag and the other bits read zero. Writing 0 to bit 0 clears the flag, and writing 1 has no effect. A match in the same cycle as a clear leaves the flag set.
- R8: The count steps from 0xFFFFFFFF to 0x00000000.
- R9: Offsets above 0x0D read zero, and writes to them change no register.
- R10: `reg_rdata` is loaded at the clock edge where `reg_rd` is high and holds its value while `reg_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle seconds enable |
| reg_addr | input | ADDR_W | Byte address of the register |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Registered read data |
| alarm_irq | output | 1 | Alarm interrupt, level high while pending |

## Verification
A table of write-then-read pairs runs with counting stopped. It separates the read-back registers from the write-only and unmapped offsets, and it shows that writing 1 to the pending bit does not set it. The time-load tests compare the count read after the zeroing write with the count read after staging. This shows that the upper bytes take effect only on the commit, and a commit issued together with a tick shows which of the two wins. The alarm is driven towards its value by ticks with the enable on and with it off. It is also driven there by a load, and once more with a clear in the same cycle as the match, so that a flag raised by the wrong event shows up on `alarm_irq`.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned COUNT_W    = BYTE_W * WORD_BYTES;

  // register offsets; the window bases fix byte order for software
  localparam int unsigned OFS_CTRL     = 0;
  localparam int unsigned OFS_ALM_CTRL = 1;
  localparam int unsigned OFS_LOAD     = 2;
  localparam int unsigned OFS_LIVE     = 6;
  localparam int unsigned OFS_ALARM    = 10;
  localparam int unsigned OFS_END      = OFS_ALARM + WORD_BYTES;

  localparam int unsigned CTRL_RUN_BIT = 7;
  localparam int unsigned CTRL_ALM_BIT = 1;
  localparam int unsigned PEND_BIT     = 0;

  function automatic logic in_win(input logic [31:0] a, input int unsigned base);
    return (a >= base) && (a < base + WORD_BYTES);
  endfunction

  function automatic logic [1:0] win_idx(input logic [31:0] a, input int unsigned base);
    logic [31:0] d;
    d = a - base;
    return d[1:0];
  endfunction

  function automatic logic [BYTE_W-1:0] pick_byte(input logic [COUNT_W-1:0] w,
                                                  input logic [1:0] idx);
    return w[idx*BYTE_W +: BYTE_W];
  endfunction

  function automatic logic [COUNT_W-1:0] next_count(input logic [COUNT_W-1:0] c);
    return c + 1'b1;
  endfunction
endpackage

// File: rtl/rtc_regs.sv
module rtc_regs
  import rtc_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wr_en,
  input  logic [BYTE_W-1:0]   wr_data,
  input  logic                rd_en,
  input  logic [COUNT_W-1:0]  count,
  input  logic                pending,
  output logic [BYTE_W-1:0]   rd_data,
  output logic                run,
  output logic                alm_en,
  output logic [COUNT_W-1:0]  alarm_val,
  output logic                load_en,
  output logic [COUNT_W-1:0]  load_val,
  output logic                pend_clr
);
  logic [31:0] a_ix;
  assign a_ix = 32'(addr);

  logic hit_ctrl, hit_actl, hit_load, hit_live, hit_alarm, unmapped;
  assign hit_ctrl  = (a_ix == OFS_CTRL);
  assign hit_actl  = (a_ix == OFS_ALM_CTRL);
  assign hit_load  = in_win(a_ix, OFS_LOAD);
  assign hit_live  = in_win(a_ix, OFS_LIVE);
  assign hit_alarm = in_win(a_ix, OFS_ALARM);
  assign unmapped  = (a_ix >= OFS_END);

  logic [BYTE_W-1:0] ctrl_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                ctrl_q <= '0;
    else if (wr_en && hit_ctrl) ctrl_q <= wr_data;
  end
  assign run    = ctrl_q[CTRL_RUN_BIT];
  assign alm_en = ctrl_q[CTRL_ALM_BIT];

  // alarm value bytes
  logic [BYTE_W-1:0] alm_q [WORD_BYTES];
  for (genvar b = 0; b < WORD_BYTES; b++) begin : g_alarm
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) alm_q[b] <= '0;
      else if (wr_en && hit_alarm && (win_idx(a_ix, OFS_ALARM) == b[1:0]))
        alm_q[b] <= wr_data;
    end
    assign alarm_val[b*BYTE_W +: BYTE_W] = alm_q[b];
  end

  // staging for upper load bytes; byte 0 is taken straight from the bus
  logic [BYTE_W-1:0] stg_q [1:WORD_BYTES-1];
  for (genvar b = 1; b < WORD_BYTES; b++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[b] <= '0;
      else if (wr_en && hit_load && (win_idx(a_ix, OFS_LOAD) == b[1:0]))
        stg_q[b] <= wr_data;
    end
    assign load_val[b*BYTE_W +: BYTE_W] = stg_q[b];
  end
  assign load_val[BYTE_W-1:0] = wr_data;
  assign load_en  = wr_en && (a_ix == OFS_LOAD);
  assign pend_clr = wr_en && hit_actl && !wr_data[PEND_BIT];

  logic [BYTE_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (hit_ctrl)       rd_mux = ctrl_q;
    else if (hit_actl)  rd_mux[PEND_BIT] = pending;
    else if (hit_live)  rd_mux = pick_byte(count, win_idx(a_ix, OFS_LIVE));
    else if (hit_alarm) rd_mux = pick_byte(alarm_val, win_idx(a_ix, OFS_ALARM));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

  assert_unmapped_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && unmapped) |=> (rd_data == '0));
  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
  assert_ctrl_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && unmapped) |=> $stable(ctrl_q));
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter
  import rtc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               tick,
  input  logic               load_en,
  input  logic [COUNT_W-1:0] load_val,
  output logic [COUNT_W-1:0] count,
  output logic               step
);
  assign step = run && tick && !load_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (load_en) count <= load_val;
    else if (step)    count <= next_count(count);
  end

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load_en) |=> (count == $past(count)));
  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !load_en && count != '1) |=> (count > $past(count)));
  assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (count == $past(load_val)));
  assert_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step && count == '1) |=> (count == '0));
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
  import rtc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step,
  input  logic               alm_en,
  input  logic [COUNT_W-1:0] count,
  input  logic [COUNT_W-1:0] alarm_val,
  input  logic               pend_clr,
  output logic               pending,
  output logic               match
);
  // compare against the value the count takes at this edge
  assign match = step && alm_en && (next_count(count) == alarm_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pending <= 1'b0;
    else if (match)    pending <= 1'b1;
    else if (pend_clr) pending <= 1'b0;
  end

  assert_pend_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !pend_clr) |=> pending);
  assert_no_spurious_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending && !match) |=> !pending);
  assert_match_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> pending);
  assert_match_needs_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> (alm_en && step));
endmodule

// File: rtl/sec_rtc.sv
module sec_rtc
  import rtc_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  input  logic              reg_rd,
  output logic [7:0]        reg_rdata,
  output logic              alarm_irq
);
  logic [COUNT_W-1:0] count, alarm_val, load_val;
  logic run, alm_en, load_en, pend_clr, pending, step, match;

  rtc_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr_en(reg_wr),
    .wr_data(reg_wdata), .rd_en(reg_rd), .count(count), .pending(pending),
    .rd_data(reg_rdata), .run(run), .alm_en(alm_en), .alarm_val(alarm_val),
    .load_en(load_en), .load_val(load_val), .pend_clr(pend_clr)
  );

  rtc_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(sec_tick),
    .load_en(load_en), .load_val(load_val), .count(count), .step(step)
  );

  rtc_alarm u_alm (
    .clk(clk), .rst_n(rst_n), .step(step), .alm_en(alm_en), .count(count),
    .alarm_val(alarm_val), .pend_clr(pend_clr), .pending(pending), .match(match)
  );

  assign alarm_irq = pending;

  assert_irq_reset_R1: assert property (@(posedge clk) $rose(rst_n) |-> !alarm_irq);
endmodule

// File: tb/sim_sec_rtc.sv
module sim_sec_rtc;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam int NROWS      = 12;
  // {write addr, write data, read addr, expected}
  localparam logic [23:0] TBL [NROWS] = '{
    {4'h0, 8'h5A, 4'h0, 8'h5A},  // R2 control read-back
    {4'h0, 8'h7F, 4'h0, 8'h7F},  // R2
    {4'hA, 8'h12, 4'hA, 8'h12},  // R5 alarm byte 0
    {4'hB, 8'h34, 4'hB, 8'h34},  // R5
    {4'hC, 8'h56, 4'hC, 8'h56},  // R5
    {4'hD, 8'h78, 4'hD, 8'h78},  // R5 alarm byte 3
    {4'hE, 8'hFF, 4'hE, 8'h00},  // R9 unmapped
    {4'hF, 8'hAA, 4'hF, 8'h00},  // R9
    {4'h3, 8'h99, 4'h3, 8'h00},  // R4 staging reads zero
    {4'h1, 8'h01, 4'h1, 8'h00},  // R7 writing 1 does not set
    {4'hE, 8'hFF, 4'h0, 8'h7F},  // R9 write ignored
    {4'h0, 8'h00, 4'h0, 8'h00}   // R2
  };

  logic clk = 1'b0, rst_n = 1'b0, sec_tick = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic alarm_irq;
  int checks = 0, errors = 0;
  bit done = 0;

  sec_rtc #(.ADDR_W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata), .alarm_irq(alarm_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic read_count(output logic [31:0] v);
    logic [7:0] b;
    for (int i = 0; i < 4; i++) begin
      rd(4'(6 + i), b);
      v[i*8 +: 8] = b;
    end
  endtask

  task automatic load(input logic [31:0] v);
    wr(4'h2, 8'h00);
    wr(4'h3, v[15:8]);
    wr(4'h4, v[23:16]);
    wr(4'h5, v[31:24]);
    wr(4'h2, v[7:0]);
  endtask

  task automatic ticks(input int n);
    sec_tick = 1'b1;
    repeat (n) @(negedge clk);
    sec_tick = 1'b0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic [7:0]  b;
    logic [31:0] c0, c1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 rdata after reset", 32'(reg_rdata), 32'h0);
    check("R1 irq after reset", 32'(alarm_irq), 32'h0);
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), b);
      check($sformatf("R1 offset %0d after reset", a), 32'(b), 32'h0);
    end

    // register table: R2 R5 R7 R9 R4
    for (int i = 0; i < NROWS; i++) begin
      wr(TBL[i][23:20], TBL[i][19:12]);
      rd(TBL[i][11:8], b);
      check($sformatf("R2 R4 R5 R7 R9 table row %0d", i), 32'(b), 32'(TBL[i][7:0]));
    end

    // R4 staging has no effect until byte 0 is written
    wr(4'h2, 8'h00);
    read_count(c0);
    check("R4 commit uses staged byte", c0, 32'h0000_9900);
    wr(4'h3, 8'h22); wr(4'h4, 8'h33); wr(4'h5, 8'h44);
    read_count(c1);
    check("R4 staging leaves count", c1, c0);
    wr(4'h2, 8'h11);
    read_count(c1);
    check("R2 R4 load and byte order", c1, 32'h4433_2211);

    // R3 hold while stopped, then count
    ticks(3);
    read_count(c1);
    check("R3 hold while stopped", c1, 32'h4433_2211);
    wr(4'h0, 8'h80);
    ticks(3);
    read_count(c1);
    check("R3 count three ticks", c1, 32'h4433_2214);

    // R4 load wins over same-cycle tick
    wr(4'h2, 8'h00); wr(4'h3, 8'hAB); wr(4'h4, 8'h00); wr(4'h5, 8'h00);
    reg_addr = 4'h2; reg_wdata = 8'h10; reg_wr = 1'b1; sec_tick = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; sec_tick = 1'b0;
    read_count(c1);
    check("R4 load over tick", c1, 32'h0000_AB10);

    // R8 wrap
    load(32'hFFFF_FFFF);
    ticks(1);
    read_count(c1);
    check("R8 wrap to zero", c1, 32'h0);

    // R6 R7 alarm match
    wr(4'hA, 8'h05); wr(4'hB, 8'h01); wr(4'hC, 8'h00); wr(4'hD, 8'h00);
    load(32'h0000_0103);
    wr(4'h0, 8'h82);
    ticks(1);
    check("R6 no irq before match", 32'(alarm_irq), 32'h0);
    ticks(1);
    check("R6 irq on match", 32'(alarm_irq), 32'h1);
    rd(4'h1, b);
    check("R7 pending bit reads 1", 32'(b), 32'h1);
    ticks(2);
    check("R6 irq level holds", 32'(alarm_irq), 32'h1);
    wr(4'h1, 8'h01);
    check("R7 write 1 keeps pending", 32'(alarm_irq), 32'h1);
    wr(4'h1, 8'h00);
    check("R7 write 0 clears", 32'(alarm_irq), 32'h0);

    // R6 disabled alarm
    wr(4'h0, 8'h80);
    load(32'h0000_0104);
    ticks(1);
    read_count(c1);
    check("R6 disabled count reached", c1, 32'h0000_0105);
    check("R6 disabled no irq", 32'(alarm_irq), 32'h0);

    // R6 load onto the alarm value does not set
    wr(4'h0, 8'h82);
    load(32'h0000_0105);
    check("R6 load equal no irq", 32'(alarm_irq), 32'h0);

    // R7 match beats clear in the same cycle
    load(32'h0000_0104);
    reg_addr = 4'h1; reg_wdata = 8'h00; reg_wr = 1'b1; sec_tick = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; sec_tick = 1'b0;
    check("R7 set over clear", 32'(alarm_irq), 32'h1);
    wr(4'h1, 8'h00);
    check("R7 clear after", 32'(alarm_irq), 32'h0);

    // R10 read data holds without strobe
    rd(4'h0, b);
    check("R10 read ctrl", 32'(b), 32'h82);
    reg_addr = 4'h6;
    repeat (2) @(negedge clk);
    check("R10 rdata holds", 32'(reg_rdata), 32'h82);

    done = 1;
    summary();
  end
endmodule